// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block runs the external memory bus of a small 8-bit controller core. The bus has one byte lane that carries the low address byte first and the data byte after it, and an upper port that can supply more address bits. Each transfer is one machine cycle, framed by an address strobe and a data strobe. A read/write line and a data-memory select travel with each transfer. The core starts a transfer with a one-cycle start pulse that carries a 16-bit address, a direction, a program/data selector and the write byte. The block answers with a one-cycle done pulse, and on a read it also returns the byte it captured.

Each 4-bit nibble of the upper port is set on its own, either to carry address bits (A11-A8 for the lower nibble, A15-A12 for the upper one) or to act as a general output/input pin group. A nibble set for I/O takes its value from a core-supplied output byte and its drive enable from a direction field. A float setting turns off the drivers of the byte lane, the upper-port address nibbles and the strobe/control pins all at once, so another master can use the bus. An extended-timing setting adds wait clocks to the data strobe for slow memories. The settings are loaded together with a single write pulse.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset the strobes, the read/write line and the data-memory select are all high, the byte lane is not driven (`ad_oe`=0), the control drivers are on (`ctl_oe`=1), every upper-port bit is undriven (`up_oe`=0, no nibble in address mode), and `busy` and `rsp_done` are low.
- R2: When `req_start` is sampled high while idle, the transfer runs over consecutive clocks in this order: address out, address strobe low, address strobe high, turnaround, data strobe low, then data strobe high with `rsp_done` high for that single clock. `busy` stays high from the first of these clocks to the last.
- R3: `ad_o` carries A7-A0 with `ad_oe`=1 for the first three clocks, so the address is still valid when the address strobe rises. On a read the lane is released (`ad_oe`=0) from the turnaround clock on.
- R4: On a read, the value on `ad_i` at the clock edge where the data strobe rises appears on `rsp_rdata` in the done clock and is held there until the next read.
- R5: On a write, `ad_o` carries the write byte with `ad_oe`=1 from the turnaround clock through the done clock. `rw_o` is 0 (write) or 1 (read) from the address clock through the done clock.
- R6: `dm_n_o` is 0 for a data-memory transfer (`req_data_mem`=1) and 1 for a program-memory transfer, from the address clock through the done clock. It is 1 when idle.
- R7: With extended timing set, the data strobe stays low for 1+EXT_WAIT clocks (3 by default), and the done pulse moves back by the same number of clocks.
- R8: Bit n of `cfg_nib_addr` puts upper nibble n in address mode. It then drives the matching address nibble of the last transfer with its enables on. A nibble in I/O mode drives `up_gpio` and uses `cfg_up_dir` as its per-bit enables (1 = drive).
- R9: With float set, `ad_oe`, `ctl_oe` and the enables of the address-mode nibbles stay 0 for the whole transfer. I/O-mode nibbles keep their enables, and the transfer still completes with its done pulse on time.
- R10: A `req_start` pulse that arrives while a transfer is running is ignored. No second transfer starts, and the latched address is not changed.
- R11: The address strobe goes low for exactly one clock per transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | One-cycle transfer request |
| req_addr | input | 16 | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_data_mem | input | 1 | 1 = data memory, 0 = program memory |
| req_wdata | input | 8 | Write byte |
| rsp_rdata | output | 8 | Captured read byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Transfer in progress |
| cfg_wr | input | 1 | Load all cfg_* settings |
| cfg_ext | input | 1 | Extended timing |
| cfg_float | input | 1 | Release bus drivers |
| cfg_nib_addr | input | 2 | Per-nibble address mode |
| cfg_up_dir | input | 8 | Upper-port I/O drive enables |
| up_gpio | input | 8 | Upper-port I/O output values |
| ad_i | input | 8 | Byte lane input |
| ad_o | output | 8 | Byte lane output value |
| ad_oe | output | 1 | Byte lane drive enable |
| up_o | output | 8 | Upper-port output value |
| up_oe | output | 8 | Upper-port per-bit drive enable |
| as_n_o | output | 1 | Address strobe, low active |
| ds_n_o | output | 1 | Data strobe, low active |
| rw_o | output | 1 | High = read, low = write |
| dm_n_o | output | 1 | Low = data-memory transfer |
| ctl_oe | output | 1 | Drive enable of strobes, read/write and select |

## Verification
The bench uses the default parameters: a 16-bit address, an 8-bit lane, two upper nibbles and an extended wait of two clocks. With these values it can check every phase clock by clock in both the 6-clock normal transfer and the 8-clock extended one. The two nibbles can be set to lower-only, both, or neither address mode, and float can be combined with a mixed nibble setting so that address nibbles and I/O nibbles are seen to behave differently.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_ASL  = 3'd2,
    PH_ASH  = 3'd3,
    PH_TURN = 3'd4,
    PH_DSL  = 3'd5,
    PH_DSH  = 3'd6
  } xbus_phase_e;
endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int EXT_WAIT = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        ext,
  output xbus_phase_e phase,
  output logic        take,
  output logic        cap_en,
  output logic        done
);
  localparam int WW = (EXT_WAIT < 1) ? 1 : $clog2(EXT_WAIT + 1);

  xbus_phase_e phase_q, phase_d;
  logic [WW-1:0] wait_q, wait_d;
  logic          wait_en;

  // next-state logic
  always_comb begin
    phase_d = phase_q;
    wait_d  = wait_q;
    wait_en = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (start) phase_d = PH_ADDR;
      PH_ADDR: phase_d = PH_ASL;
      PH_ASL:  phase_d = PH_ASH;
      PH_ASH:  phase_d = PH_TURN;
      PH_TURN: begin
        phase_d = PH_DSL;
        wait_en = 1'b1;
        wait_d  = ext ? WW'(EXT_WAIT) : '0;
      end
      PH_DSL: begin
        if (wait_q == '0) begin
          phase_d = PH_DSH;
        end else begin
          wait_en = 1'b1;
          wait_d  = wait_q - 1'b1;
        end
      end
      PH_DSH:  phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= '0;
    end else if (wait_en) begin
      wait_q <= wait_d;
    end
  end

  assign phase  = phase_q;
  assign take   = (phase_q == PH_IDLE) && start;
  assign cap_en = (phase_q == PH_DSL) && (wait_q == '0);
  assign done   = (phase_q == PH_DSH);
endmodule

// File: rtl/xbus_lane.sv
module xbus_lane
  import xbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_data_mem,
  input  logic [DW-1:0] req_wdata,
  input  xbus_phase_e   phase,
  input  logic          cap_en,
  input  logic          float_en,
  input  logic [DW-1:0] ad_i,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe,
  output logic          rw_o,
  output logic          dm_n_o,
  output logic [DW-1:0] rdata,
  output logic [AW-DW-1:0] addr_hi
);
  logic [AW-1:0] addr_q;
  logic          wr_q;
  logic          dm_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;
  logic          rd_cap;
  logic          addr_ph;
  logic          data_ph;
  logic          active;

  assign rd_cap = cap_en && !wr_q;

  // request latch, loaded only when a transfer is accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wr_q    <= 1'b0;
      dm_q    <= 1'b0;
      wdata_q <= '0;
    end else if (take) begin
      addr_q  <= req_addr;
      wr_q    <= req_write;
      dm_q    <= req_data_mem;
      wdata_q <= req_wdata;
    end
  end

  // read capture at the edge that ends the data strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_cap) begin
      rdata_q <= ad_i;
    end
  end

  always_comb begin
    addr_ph = (phase == PH_ADDR) || (phase == PH_ASL) || (phase == PH_ASH);
    data_ph = (phase == PH_TURN) || (phase == PH_DSL) || (phase == PH_DSH);
    active  = addr_ph || data_ph;
    ad_o    = '0;
    if (addr_ph) begin
      ad_o = addr_q[DW-1:0];
    end else if (data_ph && wr_q) begin
      ad_o = wdata_q;
    end
    ad_oe  = !float_en && (addr_ph || (data_ph && wr_q));
    rw_o   = active ? !wr_q : 1'b1;
    dm_n_o = active ? !dm_q : 1'b1;
  end

  assign rdata   = rdata_q;
  assign addr_hi = addr_q[AW-1:DW];
endmodule

// File: rtl/xbus_upper.sv
module xbus_upper #(
  parameter int UW   = 8,
  parameter int NIBS = 2
) (
  input  logic [UW-1:0]   addr_hi,
  input  logic [NIBS-1:0] nib_addr,
  input  logic            float_en,
  input  logic [UW-1:0]   gpio_val,
  input  logic [UW-1:0]   gpio_dir,
  output logic [UW-1:0]   up_o,
  output logic [UW-1:0]   up_oe
);
  for (genvar n = 0; n < NIBS; n++) begin : g_nib
    always_comb begin
      if (nib_addr[n]) begin
        up_o[4*n +: 4]  = addr_hi[4*n +: 4];
        up_oe[4*n +: 4] = {4{!float_en}};
      end else begin
        up_o[4*n +: 4]  = gpio_val[4*n +: 4];
        up_oe[4*n +: 4] = gpio_dir[4*n +: 4];
      end
    end
  end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int EXT_WAIT = 2,
  localparam int UW      = AW - DW,
  localparam int NIBS    = UW / 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_start,
  input  logic [AW-1:0]   req_addr,
  input  logic            req_write,
  input  logic            req_data_mem,
  input  logic [DW-1:0]   req_wdata,
  output logic [DW-1:0]   rsp_rdata,
  output logic            rsp_done,
  output logic            busy,
  input  logic            cfg_wr,
  input  logic            cfg_ext,
  input  logic            cfg_float,
  input  logic [NIBS-1:0] cfg_nib_addr,
  input  logic [UW-1:0]   cfg_up_dir,
  input  logic [UW-1:0]   up_gpio,
  input  logic [DW-1:0]   ad_i,
  output logic [DW-1:0]   ad_o,
  output logic            ad_oe,
  output logic [UW-1:0]   up_o,
  output logic [UW-1:0]   up_oe,
  output logic            as_n_o,
  output logic            ds_n_o,
  output logic            rw_o,
  output logic            dm_n_o,
  output logic            ctl_oe
);
  logic            ext_q, float_q;
  logic [NIBS-1:0] nib_q;
  logic [UW-1:0]   dir_q;

  xbus_phase_e   phase;
  logic          take, cap_en, done;
  logic [UW-1:0] addr_hi;

  // settings register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q   <= 1'b0;
      float_q <= 1'b0;
      nib_q   <= '0;
      dir_q   <= '0;
    end else if (cfg_wr) begin
      ext_q   <= cfg_ext;
      float_q <= cfg_float;
      nib_q   <= cfg_nib_addr;
      dir_q   <= cfg_up_dir;
    end
  end

  xbus_seq #(.EXT_WAIT(EXT_WAIT)) i_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (req_start),
    .ext    (ext_q),
    .phase  (phase),
    .take   (take),
    .cap_en (cap_en),
    .done   (done)
  );

  xbus_lane #(.AW(AW), .DW(DW)) i_lane (
    .clk          (clk),
    .rst_n        (rst_n),
    .take         (take),
    .req_addr     (req_addr),
    .req_write    (req_write),
    .req_data_mem (req_data_mem),
    .req_wdata    (req_wdata),
    .phase        (phase),
    .cap_en       (cap_en),
    .float_en     (float_q),
    .ad_i         (ad_i),
    .ad_o         (ad_o),
    .ad_oe        (ad_oe),
    .rw_o         (rw_o),
    .dm_n_o       (dm_n_o),
    .rdata        (rsp_rdata),
    .addr_hi      (addr_hi)
  );

  xbus_upper #(.UW(UW), .NIBS(NIBS)) i_upper (
    .addr_hi  (addr_hi),
    .nib_addr (nib_q),
    .float_en (float_q),
    .gpio_val (up_gpio),
    .gpio_dir (dir_q),
    .up_o     (up_o),
    .up_oe    (up_oe)
  );

  assign as_n_o   = (phase != PH_ASL);
  assign ds_n_o   = (phase != PH_DSL);
  assign ctl_oe   = !float_q;
  assign busy     = (phase != PH_IDLE);
  assign rsp_done = done;
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic as_n_o,
  input logic ds_n_o,
  input logic rw_o,
  input logic dm_n_o,
  input logic ad_oe,
  input logic ctl_oe,
  input logic rsp_done,
  input logic busy
);
  // R11: address strobe low for a single clock
  a_r11_as_single: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(as_n_o) |=> as_n_o);

  // R2: done follows the rise of the data strobe
  a_r2_done_after_ds: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (ds_n_o && $past(!ds_n_o)));

  // R2: strobes only while busy
  a_r2_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n_o || !ds_n_o) |-> busy);

  // R3: lane released while a read holds the data strobe low
  a_r3_read_float: assert property (@(posedge clk) disable iff (!rst_n)
    (!ds_n_o && rw_o) |-> !ad_oe);

  // R5: direction held for a whole transfer
  a_r5_rw_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rw_o));

  // R6: memory select held for a whole transfer
  a_r6_dm_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(dm_n_o));

  // R9: floating control pins imply a floating lane
  a_r9_float_lane: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_oe |-> !ad_oe);
endmodule

bind xbus_ctrl xbus_ctrl_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .as_n_o   (as_n_o),
  .ds_n_o   (ds_n_o),
  .rw_o     (rw_o),
  .dm_n_o   (dm_n_o),
  .ad_oe    (ad_oe),
  .ctl_oe   (ctl_oe),
  .rsp_done (rsp_done),
  .busy     (busy)
);

// File: tb/test_xbus_ctrl.sv
`timescale 1ns/1ps
module test_xbus_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_start, req_write, req_data_mem;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata, rsp_rdata;
  logic        rsp_done, busy;
  logic        cfg_wr, cfg_ext, cfg_float;
  logic [1:0]  cfg_nib_addr;
  logic [7:0]  cfg_up_dir, up_gpio, ad_i, ad_o, up_o, up_oe;
  logic        ad_oe, as_n_o, ds_n_o, rw_o, dm_n_o, ctl_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  xbus_ctrl i_xbus_ctrl (.*);

  // vector: ext, write, data_mem, addr, wdata, read byte
  localparam int NV = 6;
  localparam logic [34:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 16'h1234, 8'h00, 8'hA7},
    {1'b0, 1'b1, 1'b1, 16'h8001, 8'h5C, 8'h00},
    {1'b1, 1'b0, 1'b1, 16'hFFFE, 8'h00, 8'h3C},
    {1'b1, 1'b1, 1'b0, 16'h00FF, 8'h81, 8'h00},
    {1'b0, 1'b0, 1'b1, 16'h0F0F, 8'h00, 8'h00},
    {1'b0, 1'b1, 1'b0, 16'h7E80, 8'hFF, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic set_cfg(input logic ext, input logic flt, input logic [1:0] nib, input logic [7:0] dir);
    @(negedge clk);
    cfg_ext = ext; cfg_float = flt; cfg_nib_addr = nib; cfg_up_dir = dir; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // runs one transfer and checks every clock of it
  task automatic xfer(input logic ext, input logic wr, input logic dm, input logic [15:0] a,
                      input logic [7:0] wd, input logic [7:0] rd, input logic flt);
    int w, last;
    w = ext ? 3 : 1;
    last = 5 + w;
    @(negedge clk);
    req_start = 1'b1; req_addr = a; req_write = wr; req_data_mem = dm; req_wdata = wd;
    ad_i = ~rd;
    for (int p = 1; p <= last; p++) begin
      @(negedge clk);
      req_start = 1'b0;
      ad_i = (p >= 5 && p < last) ? rd : ~rd;
      chk("R2 as_n", as_n_o, (p == 2) ? 0 : 1);
      chk(ext ? "R7 ds_n" : "R2 ds_n", ds_n_o, (p >= 5 && p < last) ? 0 : 1);
      chk("R2 done", rsp_done, (p == last) ? 1 : 0);
      chk("R2 busy", busy, 1);
      chk("R5 rw", rw_o, !wr);
      chk("R6 dm_n", dm_n_o, !dm);
      if (flt) begin
        chk("R9 ad_oe", ad_oe, 0);
        chk("R9 ctl_oe", ctl_oe, 0);
      end else if (p <= 3) begin
        chk("R3 addr lane", {ad_oe, ad_o}, {1'b1, a[7:0]});
      end else if (wr) begin
        chk("R5 wdata lane", {ad_oe, ad_o}, {1'b1, wd});
      end else begin
        chk("R3 read float", ad_oe, 0);
      end
      if (p == last && !wr) chk("R4 rdata", rsp_rdata, rd);
    end
    @(negedge clk);
    chk("R2 idle after", {busy, rsp_done, as_n_o, ds_n_o, rw_o, dm_n_o}, 6'b001111);
  endtask

  initial begin
    int as_cnt, dn_cnt;
    rst_n = 1'b0; req_start = 0; req_addr = 0; req_write = 0; req_data_mem = 0;
    req_wdata = 0; cfg_wr = 0; cfg_ext = 0; cfg_float = 0; cfg_nib_addr = 0;
    cfg_up_dir = 0; up_gpio = 8'hA5; ad_i = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 strobes", {as_n_o, ds_n_o, rw_o, dm_n_o}, 4'hF);
    chk("R1 oe", {ad_oe, ctl_oe, up_oe}, {1'b0, 1'b1, 8'h00});
    chk("R1 busy/done", {busy, rsp_done}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {busy, up_oe}, 9'h000);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      set_cfg(VEC[i][34], 1'b0, 2'b11, 8'h00);
      xfer(VEC[i][34], VEC[i][33], VEC[i][32], VEC[i][31:16], VEC[i][15:8], VEC[i][7:0], 1'b0);
      chk("R8 both nibbles", {up_oe, up_o}, {8'hFF, VEC[i][31:24]});
    end
    chk("R4 rdata held over writes", rsp_rdata, 8'h00);

    // R8 lower nibble address, upper nibble I/O
    set_cfg(1'b0, 1'b0, 2'b01, 8'hF0);
    xfer(1'b1 ^ 1'b1, 1'b1, 1'b0, 16'h3C12, 8'h44, 8'h00, 1'b0);
    chk("R8 mixed up_o", up_o, 8'hAC);
    chk("R8 mixed up_oe", up_oe, 8'hFF);
    set_cfg(1'b0, 1'b0, 2'b00, 8'h0F);
    chk("R8 all io", {up_oe, up_o}, {8'h0F, 8'hA5});

    // R9 float with mixed nibbles
    set_cfg(1'b0, 1'b1, 2'b01, 8'hF0);
    xfer(1'b0, 1'b0, 1'b1, 16'h9921, 8'h00, 8'h6E, 1'b1);
    chk("R9 nibble oe", up_oe, 8'hF0);

    // R10 start while busy ignored, R11 one strobe
    set_cfg(1'b0, 1'b0, 2'b11, 8'h00);
    @(negedge clk);
    req_start = 1'b1; req_addr = 16'h5A01; req_write = 1'b0;
    as_cnt = 0; dn_cnt = 0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      req_start = (c == 2);
      if (c == 2) req_addr = 16'hC3FF;
      if (!as_n_o) as_cnt++;
      if (rsp_done) dn_cnt++;
    end
    chk("R11 one address strobe", as_cnt, 1);
    chk("R10 one done", dn_cnt, 1);
    chk("R10 address kept", up_o, 8'h5A);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule